// File: doc/BRIEF.md
# Page Pointer Prefetcher

This block keeps a receive data path supplied with 4 KB buffer pages. The host places page-pointer descriptors in a circular queue and programs a limit register that marks how far the queue is valid. The block walks a fetch pointer towards that limit. Whenever its small local buffer has room and unfetched entries remain, it requests one descriptor. It stores the returned page address and hands the addresses to the consumer one at a time, in order.

When the descriptor at the last valid queue location is fetched, the block raises a low-space attention. At that moment the consumer still has exactly one page in hand beyond what it has used. When the fetch pointer reaches the limit, fetching halts. It restarts without further host action once the limit register is moved forward. The attention is owned by hardware. It is set at reset and by a last-entry fetch, and it is cleared by the fetch of any other entry. A host write aimed at it has no effect.

A three-state controller sequences the fetches. **IDLE** goes to **HALT** when the fetch pointer equals the limit, and goes to **FETCH** when the pointer differs from the limit and the buffer has a free slot. **FETCH** holds the request and returns to **IDLE** when the response is accepted. **HALT** returns to **IDLE** once the limit no longer equals the fetch pointer.

Top module: `ppf_prefetch`

## Requirements
- R1: After reset `low_space_attn` is 1, `pg_stall` is 1, `fetch_req` is 0, and both the fetch pointer and the limit are 0, so the block starts halted.
- R2: A request (`fetch_req` rising) starts only when the buffer has a free slot and the fetch pointer differs from the limit.
- R3: While `fetch_req` is high, `fetch_idx` equals the fetch pointer and stays stable until `rsp_valid` is seen with it. A response is accepted when `fetch_req` and `rsp_valid` are both high at a clock edge.
- R4: The address stored for the consumer is `rsp_addr` with bits 11:0 forced to zero.
- R5: An accepted fetch from index limit−1 (modulo 2^IDX_W) sets `low_space_attn` to 1.
- R6: An accepted fetch from any other index clears `low_space_attn` to 0.
- R7: `sw_attn_wr` has no effect, whatever `sw_attn_data` holds. `low_space_attn` changes only at an accepted fetch.
- R8: When the fetch pointer equals the limit, no request is issued. After `lim_wr` moves the limit away from the pointer, fetching resumes without any other input.
- R9: The buffer holds BUF_DEPTH (2) addresses in first-in first-out order. `pg_addr` shows the oldest entry, and `pg_pop` removes it.
- R10: `pg_stall` is 1 exactly when the buffer is empty. A `pg_pop` while empty changes nothing.
- R11: When `low_space_attn` rises, at least one page address is waiting (`pg_stall` is 0).
- R12: The fetch pointer wraps from 2^IDX_W−1 to 0, and the limit comparison works across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_wr | input | 1 | Host write strobe for the queue limit |
| lim_data | input | IDX_W | New limit index (one past the last valid entry) |
| sw_attn_wr | input | 1 | Host write strobe aimed at the attention bit (ignored) |
| sw_attn_data | input | 1 | Value carried by that write (ignored) |
| fetch_req | output | 1 | Descriptor fetch request, held until response |
| fetch_idx | output | IDX_W | Queue index being fetched |
| rsp_valid | input | 1 | Descriptor response valid |
| rsp_addr | input | ADDR_W | Page address returned for the descriptor |
| pg_pop | input | 1 | Consumer takes the page address at the head |
| pg_addr | output | ADDR_W | Oldest buffered page address |
| pg_stall | output | 1 | No page address available |
| low_space_attn | output | 1 | Low data space attention |

## Verification
The assertions assume that the responder raises `rsp_valid` only while `fetch_req` is high. They also assume that the host moves the limit only forward, and never onto the index currently being requested. The bench keeps to this. Its memory model answers one cycle after it sees a request and drops the response after the accepting edge. Every limit write the bench makes raises the limit past the fetch pointer, or wraps it forward while the block is halted. Consumer pops are pulsed for a single cycle and are sometimes issued on an empty buffer on purpose.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

    localparam int PAGE_BITS = 12;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_HALT  = 2'd2
    } fetch_state_t;

endpackage

// File: rtl/ppf_fifo.sv
module ppf_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             room
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] count;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok = pop && (count != '0);
    assign dout   = mem[rp];
    assign empty  = (count == '0);
    assign room   = (count < FULL_CNT);

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push)   wp <= step(wp);
            if (pop_ok) rp <= step(rp);
            unique case ({push, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < FULL_CNT));

    a_r10_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (count == '0) && !push) |=> (count == '0));

endmodule

// File: rtl/ppf_fetch_fsm.sv
module ppf_fetch_fsm
    import ppf_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_wr,
    input  logic [IDX_W-1:0] lim_data,
    input  logic             sw_attn_wr,
    input  logic             sw_attn_data,
    input  logic             room,
    input  logic             rsp_valid,
    output logic             fetch_req,
    output logic [IDX_W-1:0] fetch_idx,
    output logic             push,
    output logic             attn
);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    fetch_state_t     state, nxt;
    logic [IDX_W-1:0] ptr, lim;
    logic             accept;
    logic             at_limit;

    assign at_limit = (ptr == lim);
    assign accept   = (state == S_FETCH) && rsp_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (at_limit)  nxt = S_HALT;
                else if (room) nxt = S_FETCH;
            end
            S_FETCH: if (rsp_valid) nxt = S_IDLE;
            S_HALT:  if (!at_limit) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        fetch_req = (state == S_FETCH);
        fetch_idx = ptr;
        push      = accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr  <= '0;
            lim  <= '0;
            attn <= 1'b1;
        end else begin
            if (lim_wr) lim <= lim_data;
            if (accept) begin
                ptr  <= ptr + ONE;
                attn <= (ptr == lim - ONE);
            end
        end
    end

    a_r2_req_start_ok: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> (room && (fetch_idx != lim)));

    a_r3_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !rsp_valid) |=> (fetch_req && $stable(fetch_idx)));

    a_r7_attn_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_attn_wr || sw_attn_data || !sw_attn_wr) && !(fetch_req && rsp_valid))
            |=> $stable(attn));

    a_r8_no_req_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (at_limit && !fetch_req) |=> !fetch_req);

endmodule

// File: rtl/ppf_prefetch.sv
module ppf_prefetch
    import ppf_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int ADDR_W    = 32,
    parameter int BUF_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lim_wr,
    input  logic [IDX_W-1:0]  lim_data,
    input  logic              sw_attn_wr,
    input  logic              sw_attn_data,
    output logic              fetch_req,
    output logic [IDX_W-1:0]  fetch_idx,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic              pg_pop,
    output logic [ADDR_W-1:0] pg_addr,
    output logic              pg_stall,
    output logic              low_space_attn
);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((1 << PAGE_BITS) - 1);

    logic              room;
    logic              push;
    logic [ADDR_W-1:0] page_aligned;

    assign page_aligned = rsp_addr & ~OFS_MASK;

    ppf_fetch_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .lim_wr       (lim_wr),
        .lim_data     (lim_data),
        .sw_attn_wr   (sw_attn_wr),
        .sw_attn_data (sw_attn_data),
        .room         (room),
        .rsp_valid    (rsp_valid),
        .fetch_req    (fetch_req),
        .fetch_idx    (fetch_idx),
        .push         (push),
        .attn         (low_space_attn)
    );

    ppf_fifo #(.WIDTH(ADDR_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (page_aligned),
        .pop   (pg_pop),
        .dout  (pg_addr),
        .empty (pg_stall),
        .room  (room)
    );

    a_r11_attn_leaves_page: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_space_attn) |-> !pg_stall);

endmodule

// File: tb/test_ppf_prefetch.sv
`timescale 1ns/1ps
module test_ppf_prefetch;
    localparam int IDX_W  = 4;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lim_wr = 1'b0;
    logic [IDX_W-1:0]  lim_data = '0;
    logic              sw_attn_wr = 1'b0;
    logic              sw_attn_data = 1'b0;
    logic              fetch_req;
    logic [IDX_W-1:0]  fetch_idx;
    logic              rsp_valid = 1'b0;
    logic [ADDR_W-1:0] rsp_addr = '0;
    logic              pg_pop = 1'b0;
    logic [ADDR_W-1:0] pg_addr;
    logic              pg_stall;
    logic              low_space_attn;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ppf_prefetch #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .BUF_DEPTH(2)) i_ppf_prefetch (
        .clk(clk), .rst_n(rst_n), .lim_wr(lim_wr), .lim_data(lim_data),
        .sw_attn_wr(sw_attn_wr), .sw_attn_data(sw_attn_data),
        .fetch_req(fetch_req), .fetch_idx(fetch_idx),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .pg_pop(pg_pop), .pg_addr(pg_addr), .pg_stall(pg_stall),
        .low_space_attn(low_space_attn)
    );

    function automatic logic [ADDR_W-1:0] raw_addr(input logic [IDX_W-1:0] idx);
        return 32'h0040_0000 + (32'(idx) << 12) + 32'h0000_0A5C + 32'(idx);
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [IDX_W-1:0] idx);
        return 32'h0040_0000 + (32'(idx) << 12);
    endfunction

    // memory responder: answers one cycle after it sees a request
    initial begin
        forever begin
            @(negedge clk);
            if (fetch_req && !rsp_valid) begin
                rsp_valid = 1'b1;
                rsp_addr  = raw_addr(fetch_idx);
            end else begin
                rsp_valid = 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [ADDR_W-1:0] act,
                         input logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_limit(input logic [IDX_W-1:0] v);
        lim_data = v;
        lim_wr   = 1'b1;
        @(negedge clk);
        lim_wr   = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [IDX_W-1:0] idx);
        for (int i = 0; i < 40 && pg_stall; i++) @(negedge clk);
        check(req, {31'd0, pg_stall}, 32'd0);
        check(req, pg_addr, exp_addr(idx));
        pg_pop = 1'b1;
        @(negedge clk);
        pg_pop = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 attn", {31'd0, low_space_attn}, 32'd1);
        check("R1 stall", {31'd0, pg_stall}, 32'd1);
        check("R1 req", {31'd0, fetch_req}, 32'd0);
        wait_cyc(4);
        check("R8 halted at reset", {31'd0, fetch_req}, 32'd0);
    endtask

    task automatic t_first_batch();
        write_limit(4'd3);
        wait_cyc(14);
        check("R6 attn cleared by fresh fetch", {31'd0, low_space_attn}, 32'd0);
        check("R2 no req when buffer full", {31'd0, fetch_req}, 32'd0);
        pop_expect("R4 R9 head entry 0", 4'd0);
        wait_cyc(8);
        check("R5 attn on last entry", {31'd0, low_space_attn}, 32'd1);
        check("R11 page waiting at attn", {31'd0, pg_stall}, 32'd0);
        pop_expect("R9 order entry 1", 4'd1);
        pop_expect("R9 order entry 2", 4'd2);
        wait_cyc(6);
        check("R10 stall when empty", {31'd0, pg_stall}, 32'd1);
        check("R8 halt at limit", {31'd0, fetch_req}, 32'd0);
    endtask

    task automatic t_sw_write();
        sw_attn_data = 1'b0;
        sw_attn_wr   = 1'b1;
        @(negedge clk);
        sw_attn_wr   = 1'b0;
        wait_cyc(2);
        check("R7 sw clear ignored", {31'd0, low_space_attn}, 32'd1);
    endtask

    task automatic t_empty_pop_resume();
        pg_pop = 1'b1;
        @(negedge clk);
        pg_pop = 1'b0;
        wait_cyc(2);
        check("R10 empty pop keeps stall", {31'd0, pg_stall}, 32'd1);
        write_limit(4'd5);
        wait_cyc(14);
        check("R8 R5 resumed, last entry flagged", {31'd0, low_space_attn}, 32'd1);
        pop_expect("R10 R8 entry 3 after empty pop", 4'd3);
        pop_expect("R8 entry 4", 4'd4);
        wait_cyc(6);
        check("R8 halted again", {31'd0, fetch_req}, 32'd0);
    endtask

    task automatic t_wrap();
        write_limit(4'd1);
        pop_expect("R12 wrap entry 5", 4'd5);
        check("R6 attn clear during run", {31'd0, low_space_attn}, 32'd0);
        for (int k = 6; k <= 16; k++) begin
            pop_expect("R12 wrap sequence", 4'(k));
        end
        wait_cyc(6);
        check("R5 attn after wrapped last entry", {31'd0, low_space_attn}, 32'd1);
        check("R12 halted after wrap", {31'd0, pg_stall}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_first_batch();
        t_sw_write();
        t_empty_pop_resume();
        t_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule